// File: doc/BRIEF.md
# Film Cadence Movie-Mode Detector

This block watches an interlaced field stream for the 2:2 cadence left behind when film frames are spread over two fields. Once per field a pulse delivers a count of moving pixels. The block compares that count with the count from the previous field and forms a single compare bit from the size of the change. It keeps a history of these bits. An alternating history marks film material, and a history that does not alternate marks camera material.

The block has two outputs. `movie_o` reports the mode: 1 means film and 0 means camera. `phase_o` reports which field of a film pair the current field is. A field-level controller supplies the settings: a threshold, a time constant, a hysteresis enable, a synchronous clear and a phase inversion. A mode change only takes effect after a run of confirming fields. With hysteresis enabled, leaving film mode needs a shorter run than entering it.

Top module: `film_cadence_det`

## Requirements
- R1: On a field pulse (`field_start_i`=1, `mm_clear_i`=0) the compare bit is 1 when |`motion_cnt_i` − previous field count| ≥ 64·`mm_thresh_i`, and 0 otherwise. The previous field count is 0 after reset and is updated on every accepted field pulse.
- R2: `phase_o` equals the compare bit of the most recent accepted field XOR `phase_inv_i`. The inversion takes effect at once, without waiting for a field.
- R3: A field is counted as film-like when the newest W = 2·(`mm_tconst_i`+1) compare bits, including the current one, alternate bit to bit. Bits cleared by reset or by a clear count as 0.
- R4: `movie_o` goes from 0 to 1 in the cycle after the W-th consecutive film-like field.
- R5: With `hyst_en_i`=1, `movie_o` goes from 1 to 0 in the cycle after the (`mm_tconst_i`+1)-th consecutive field that is not film-like.
- R6: With `hyst_en_i`=0, `movie_o` goes from 1 to 0 only after W consecutive fields that are not film-like.
- R7: While `mm_clear_i` is 1, any field pulse in that cycle is discarded. In the next cycle `movie_o` is 0, the compare history is all 0 and the run count is 0. The previous field count is kept.
- R8: While `rst_ni` is 0, `movie_o` is 0 and `phase_o` equals `phase_inv_i`.
- R9: While `field_start_i` is 0, changes on `motion_cnt_i` and the settings leave `movie_o` and the phase state unchanged.
- R10: The largest time constant, 15, uses a 32-bit window. From reset, an alternating cadence that starts with a 1 sets `movie_o` after exactly the 62nd field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| field_start_i | input | 1 | One pulse per field; samples the motion count |
| motion_cnt_i | input | CNT_W | Count of moving pixels for the field |
| mm_thresh_i | input | TH_W | Compare threshold, in units of 64 |
| mm_tconst_i | input | 4 | Time constant; sets W = 2·(value+1) |
| hyst_en_i | input | 1 | Enables the shorter exit run |
| mm_clear_i | input | 1 | Synchronous clear of mode, history and run count |
| phase_inv_i | input | 1 | Inverts the phase output |
| movie_o | output | 1 | 1 = film mode, 0 = camera mode |
| phase_o | output | 1 | Film phase of the latest field |

## Verification
The properties assume that the time constant, the hysteresis enable and the threshold change only between field pulses. They also assume that a field pulse lasts one cycle and is followed by at least one idle cycle. The only exception is a clear that coincides with a pulse, and the properties cover that case. The stimulus follows these rules: it changes settings only during reset or at idle points, and every field is a single-cycle pulse followed by an idle cycle. The motion counts move in steps far from the threshold, except in the scenario that tests values exactly at the threshold and one below it.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  localparam int unsigned TC_W     = 4;
  localparam int unsigned HIST_LEN = 2 * (1 << TC_W);
  localparam int unsigned RUN_W    = $clog2(HIST_LEN + 1);

  typedef logic [RUN_W-1:0] run_t;

  // window length 2*(tc+1)
  function automatic run_t win_len(input logic [TC_W-1:0] tc);
    return (run_t'(tc) + run_t'(1)) << 1;
  endfunction
endpackage

// File: rtl/fcd_cmp.sv
module fcd_cmp #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned TH_W  = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [TH_W-1:0]  thresh_i,
  output logic             cmp_o,
  output logic [CNT_W-1:0] prev_o
);
  localparam int unsigned LIM_W = TH_W + 6;
  localparam int unsigned CW    = (CNT_W > LIM_W) ? CNT_W : LIM_W;

  logic [CNT_W-1:0] prev_q, diff;
  logic [CW-1:0]    diff_w, lim_w;

  always_comb begin
    diff   = (cnt_i >= prev_q) ? (cnt_i - prev_q) : (prev_q - cnt_i);
    diff_w = CW'(diff);
    lim_w  = CW'({thresh_i, 6'd0});
    cmp_o  = (diff_w >= lim_w);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     prev_q <= '0;
    else if (take_i) prev_q <= cnt_i;
  end

  assign prev_o = prev_q;
endmodule

// File: rtl/fcd_hist.sv
module fcd_hist
  import fcd_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            shift_i,
  input  logic            clear_i,
  input  logic            bit_i,
  input  logic [TC_W-1:0] tc_i,
  output logic            alt_o,
  output logic            last_o
);
  logic [HIST_LEN-1:0] hist_q, hist_nx;
  logic [HIST_LEN-2:0] pair_ok;

  assign hist_nx = {hist_q[HIST_LEN-2:0], bit_i};

  // pair i is inside the window when i <= 2*tc
  for (genvar i = 0; i < HIST_LEN - 1; i++) begin : g_pair
    assign pair_ok[i] = (hist_nx[i] ^ hist_nx[i+1]) | (i > 2 * int'(tc_i));
  end

  assign alt_o  = &pair_ok;
  assign last_o = hist_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       hist_q <= '0;
    else if (clear_i)  hist_q <= '0;
    else if (shift_i)  hist_q <= hist_nx;
  end
endmodule

// File: rtl/fcd_hyst.sv
module fcd_hyst
  import fcd_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            step_i,
  input  logic            clear_i,
  input  logic            alt_i,
  input  logic [TC_W-1:0] tc_i,
  input  logic            hyst_en_i,
  output logic            movie_o
);
  logic movie_q;
  run_t run_q, run_inc, need;

  always_comb begin
    run_inc = run_q + run_t'(1);
    if (movie_q && hyst_en_i) need = run_t'(tc_i) + run_t'(1);
    else                      need = win_len(tc_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      movie_q <= 1'b0;
      run_q   <= '0;
    end else if (clear_i) begin
      movie_q <= 1'b0;
      run_q   <= '0;
    end else if (step_i) begin
      if (alt_i != movie_q) begin
        if (run_inc >= need) begin
          movie_q <= alt_i;
          run_q   <= '0;
        end else begin
          run_q   <= run_inc;
        end
      end else begin
        run_q <= '0;
      end
    end
  end

  assign movie_o = movie_q;
endmodule

// File: rtl/film_cadence_det.sv
module film_cadence_det
  import fcd_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned TH_W  = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             field_start_i,
  input  logic [CNT_W-1:0] motion_cnt_i,
  input  logic [TH_W-1:0]  mm_thresh_i,
  input  logic [TC_W-1:0]  mm_tconst_i,
  input  logic             hyst_en_i,
  input  logic             mm_clear_i,
  input  logic             phase_inv_i,
  output logic             movie_o,
  output logic             phase_o
);
  logic             take, cmp, alt, last;
  logic [CNT_W-1:0] prev_cnt;

  assign take = field_start_i & ~mm_clear_i;

  fcd_cmp #(.CNT_W(CNT_W), .TH_W(TH_W)) u_cmp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .take_i   (take),
    .cnt_i    (motion_cnt_i),
    .thresh_i (mm_thresh_i),
    .cmp_o    (cmp),
    .prev_o   (prev_cnt)
  );

  fcd_hist u_hist (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (take),
    .clear_i (mm_clear_i),
    .bit_i   (cmp),
    .tc_i    (mm_tconst_i),
    .alt_o   (alt),
    .last_o  (last)
  );

  fcd_hyst u_hyst (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (take),
    .clear_i   (mm_clear_i),
    .alt_i     (alt),
    .tc_i      (mm_tconst_i),
    .hyst_en_i (hyst_en_i),
    .movie_o   (movie_o)
  );

  assign phase_o = last ^ phase_inv_i;
endmodule

// File: rtl/fcd_chk.sv
module fcd_chk #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned TH_W  = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             field_start_i,
  input logic [CNT_W-1:0] motion_cnt_i,
  input logic [TH_W-1:0]  mm_thresh_i,
  input logic             mm_clear_i,
  input logic             phase_inv_i,
  input logic             movie_o,
  input logic             phase_o,
  input logic [CNT_W-1:0] prev_cnt_i
);
  logic [CNT_W-1:0] d;
  logic             exp_cmp, ph;

  assign d       = (motion_cnt_i >= prev_cnt_i) ? (motion_cnt_i - prev_cnt_i)
                                                : (prev_cnt_i - motion_cnt_i);
  assign exp_cmp = (64'(d) >= (64'(mm_thresh_i) << 6));
  assign ph      = phase_o ^ phase_inv_i;

  AST_CMP_RULE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (field_start_i && !mm_clear_i) |=> (ph == $past(exp_cmp)));  // R1

  AST_PHASE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!field_start_i && !mm_clear_i) |=> $stable(ph));  // R2

  AST_ENTRY_ALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(movie_o) |-> (ph != $past(ph)));  // R3

  AST_EXIT_ON_FIELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(movie_o) && !$past(mm_clear_i)) |-> $past(field_start_i));  // R5

  AST_CLEAR_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mm_clear_i |=> (!movie_o && !ph));  // R7

  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!field_start_i && !mm_clear_i) |=> $stable(movie_o));  // R9
endmodule

bind film_cadence_det fcd_chk #(.CNT_W(CNT_W), .TH_W(TH_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .field_start_i (field_start_i),
  .motion_cnt_i  (motion_cnt_i),
  .mm_thresh_i   (mm_thresh_i),
  .mm_clear_i    (mm_clear_i),
  .phase_inv_i   (phase_inv_i),
  .movie_o       (movie_o),
  .phase_o       (phase_o),
  .prev_cnt_i    (prev_cnt)
);

// File: tb/film_cadence_det_tb.sv
`timescale 1ns/1ps
module film_cadence_det_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        field_start = 1'b0;
  logic [15:0] cnt = '0;
  logic [6:0]  thr = 7'd1;
  logic [3:0]  tc = 4'd1;
  logic        hyst = 1'b0;
  logic        clr = 1'b0;
  logic        inv = 1'b0;
  logic        movie_o, phase_o;

  int n_chk = 0;
  int n_fail = 0;

  // reference state
  logic [31:0] m_hist;
  logic [15:0] m_prev;
  logic        m_movie;
  int          m_run;

  always #4 clk = ~clk;

  film_cadence_det u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .field_start_i(field_start),
    .motion_cnt_i(cnt), .mm_thresh_i(thr), .mm_tconst_i(tc),
    .hyst_en_i(hyst), .mm_clear_i(clr), .phase_inv_i(inv),
    .movie_o(movie_o), .phase_o(phase_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step(input logic [15:0] c);
    int d, w, need;
    logic b, alt;
    logic [31:0] nx;
    d = (c >= m_prev) ? int'(c) - int'(m_prev) : int'(m_prev) - int'(c);
    b = (d >= 64 * int'(thr));
    m_prev = c;
    nx = {m_hist[30:0], b};
    w = 2 * (int'(tc) + 1);
    alt = 1'b1;
    for (int i = 0; i < w - 1; i++) if (nx[i] == nx[i+1]) alt = 1'b0;
    m_hist = nx;
    if (alt != m_movie) begin
      m_run++;
      need = (m_movie && hyst) ? int'(tc) + 1 : w;
      if (m_run >= need) begin
        m_movie = alt;
        m_run = 0;
      end
    end else begin
      m_run = 0;
    end
  endtask

  task automatic field(input logic [15:0] c);
    @(negedge clk);
    field_start = 1'b1;
    cnt = c;
    model_step(c);
    @(negedge clk);
    field_start = 1'b0;
    chk("R4 movie", movie_o, m_movie);
    chk("R2 phase", phase_o, m_hist[0] ^ inv);
  endtask

  task automatic do_reset(input logic [3:0] t, input logic h, input logic [6:0] th);
    @(negedge clk);
    rst_ni = 1'b0;
    tc = t; hyst = h; thr = th; inv = 1'b0; clr = 1'b0; cnt = '0;
    m_hist = '0; m_prev = '0; m_movie = 1'b0; m_run = 0;
    #1;
    chk("R8 reset movie", movie_o, 1'b0);
    chk("R8 reset phase", phase_o, 1'b0);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  // cmp pattern 1,0,1,0... starting from prev=0
  task automatic film_fields(input int n);
    for (int k = 1; k <= n; k++) field(((k % 4) == 1 || (k % 4) == 2) ? 16'd1000 : 16'd0);
  endtask

  task automatic t_threshold;
    do_reset(4'd1, 1'b0, 7'd2);
    field(16'd128);
    chk("R1 diff at limit", phase_o, 1'b1);
    field(16'd255);
    chk("R1 diff one below", phase_o, 1'b0);
    field(16'd127);
    chk("R1 diff down at limit", phase_o, 1'b1);
  endtask

  task automatic t_entry;
    do_reset(4'd1, 1'b0, 7'd1);
    film_fields(5);
    chk("R4 not yet movie", movie_o, 1'b0);
    film_fields_from(6, 6);
    chk("R4 movie after W confirms", movie_o, 1'b1);
  endtask

  task automatic film_fields_from(input int a, input int b);
    for (int k = a; k <= b; k++) field(((k % 4) == 1 || (k % 4) == 2) ? 16'd1000 : 16'd0);
  endtask

  task automatic t_exit(input logic h);
    do_reset(4'd1, h, 7'd1);
    film_fields(6);
    chk("R3 in movie", movie_o, 1'b1);
    field(16'd2000);
    field(16'd3000);
    field(16'd4000);
    if (h) begin
      chk("R5 short exit", movie_o, 1'b0);
    end else begin
      chk("R6 still movie", movie_o, 1'b1);
      field(16'd5000);
      chk("R6 still movie", movie_o, 1'b1);
      field(16'd6000);
      chk("R6 exit after W", movie_o, 1'b0);
    end
  endtask

  task automatic t_invert;
    do_reset(4'd1, 1'b0, 7'd1);
    field(16'd1000);
    @(negedge clk);
    inv = 1'b1;
    #1;
    chk("R2 inverted phase", phase_o, 1'b0);
    @(negedge clk);
    inv = 1'b0;
    #1;
    chk("R2 plain phase", phase_o, 1'b1);
  endtask

  task automatic t_idle;
    do_reset(4'd1, 1'b0, 7'd1);
    film_fields(6);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      cnt = 16'(k * 3000);
      tc = 4'(k);
      hyst = k[0];
    end
    @(negedge clk);
    tc = 4'd1; hyst = 1'b0;
    chk("R9 movie held", movie_o, 1'b1);
    chk("R9 phase held", phase_o, m_hist[0]);
  endtask

  task automatic t_clear;
    do_reset(4'd1, 1'b0, 7'd1);
    film_fields(6);
    @(negedge clk);
    clr = 1'b1;
    field_start = 1'b1;
    cnt = 16'd9000;
    m_hist = '0; m_movie = 1'b0; m_run = 0;
    @(negedge clk);
    clr = 1'b0;
    field_start = 1'b0;
    chk("R7 mode cleared", movie_o, 1'b0);
    chk("R7 history cleared", phase_o, 1'b0);
    // prev count kept at 1000: 0 gives cmp 1
    field(16'd0);
    chk("R7 prev kept", phase_o, 1'b1);
    chk("R7 no quick reentry", movie_o, 1'b0);
  endtask

  task automatic t_longwin;
    do_reset(4'd15, 1'b0, 7'd1);
    film_fields(61);
    chk("R10 not yet movie", movie_o, 1'b0);
    film_fields_from(62, 62);
    chk("R10 movie at field 62", movie_o, 1'b1);
  endtask

  initial begin
    t_threshold();
    t_entry();
    t_exit(1'b1);
    t_exit(1'b0);
    t_invert();
    t_idle();
    t_clear();
    t_longwin();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #800000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule